// File: doc/BRIEF.md
# Pixel Region Hit Buffer

This block serves a region of four neighbouring pixels in a hybrid pixel readout array. Each pixel has a discriminator line. For each pixel the block measures how many clock cycles the discriminator stays high, which gives a 4-bit time-over-threshold (ToT) charge value. It groups pixels that fire in the same clock cycle into one event. Each event takes one slot of a small buffer. A slot holds one timestamp for the whole region and one ToT field for each of the four pixels.

Events wait in the buffer for a programmable trigger latency. A trigger asks for the events whose timestamp equals the current bunch-crossing count minus the latency. Those events are marked for readout and leave through a valid/ready handshake. Events that are never requested are dropped once they are older than the latency. When a pixel starts a new hit and every slot is taken, the hit is lost and counted. The buffer depth (seven slots by default, eight allowed) and the readout style (registered or combinational) are build-time parameters.

Top module: `pix_region_buf`

## Requirements
- R1: While reset is asserted, and after it is released, `readValid` is 0 and `lostCount` is 0. Events stored before reset are never read out afterwards.
- R2: A pixel's ToT equals the number of rising clock edges at which its discriminator was sampled high, and it saturates at 15. It is written into the event when the discriminator is first sampled low again. Pixel p's ToT sits in `readTot[4p+3:4p]`.
- R3: Every clock cycle in which at least one discriminator rises opens a new event. Pixels that rise in that same cycle share the event. A pixel that rises one or more cycles later opens a separate event. Pixels that did not fire in an event read back a ToT of 0.
- R4: An event stores the value of `tsNow` from the cycle in which it was opened, and returns it on `readTs`.
- R5: A trigger sampled in a cycle where `tsNow - storedTs == latency` (modulo 2^TS_W) selects that event. A trigger in any other cycle does not select it.
- R6: With registered readout (`SYNC_READ=1`), a selected event appears on `readValid`/`readTs`/`readTot` one clock edge after the edge that sampled the trigger. Its data stays stable while `readReady` is low. The event leaves at the edge where `readValid` and `readReady` are both high.
- R7: With combinational readout (`SYNC_READ=0`), a selected event appears right after the edge that sampled the trigger.
- R8: When several events are selected, the outputs carry them one at a time and move to the next one after each accepted transfer. None is lost or repeated.
- R9: An event that has not been selected is freed at the first edge where its age exceeds the latency. Its slot can then hold a new event without loss.
- R10: When a discriminator rises while all SLOTS slots are occupied, `lostCount` grows by the number of pixels that rose in that cycle, and no event is opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bunch crossing |
| rstN | input | 1 | Asynchronous active-low reset |
| disc | input | PIX_N (4) | Discriminator outputs, one per pixel |
| tsNow | input | TS_W (8) | Current bunch-crossing count |
| latency | input | LAT_W (7) | Trigger latency in cycles |
| trigger | input | 1 | Trigger request for the crossing `tsNow - latency` |
| readReady | input | 1 | Downstream accepts the presented event |
| readValid | output | 1 | An event is presented |
| readTs | output | TS_W (8) | Timestamp of the presented event |
| readTot | output | PIX_N*TOT_W (16) | Per-pixel ToT of the presented event |
| lostCount | output | CNT_W (8) | Saturating count of lost pixel hits |

## Verification
The embedded properties assume that `tsNow` advances by one each cycle, that `latency` is held constant and is less than half the timestamp range, and that every discriminator pulse ends before its event reaches the latency. Without these, the age of a slot, and whether its ToT is final when it is selected, are not well defined. The stimulus keeps `latency` at 20 and increments `tsNow` on every cycle. Every pulse ends by its eighteenth cycle. Triggers are issued only in chosen cycles, so the expected timestamp and ToT of each readout follow directly from the pulse schedule.

// File: rtl/pix_region_pkg.sv
package pix_region_pkg;
  localparam int PIX_N    = 4;
  localparam int TOT_W    = 4;
  localparam int SLOT_MAX = 8;
  localparam int SIDX_W   = $clog2(SLOT_MAX);

  typedef logic [SIDX_W-1:0] slotIdx_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                   alloc;
    slotIdx_t               allocSlot;
    logic [PIX_N-1:0]       totWr;
    slotIdx_t [PIX_N-1:0]   totSlot;
    logic                   rdLoad;
    slotIdx_t               rdSlot;
  } strobe_t;
endpackage

// File: rtl/pix_region_store.sv
module pix_region_store
  import pix_region_pkg::*;
#(
  parameter int SLOTS     = 7,
  parameter int TS_W      = 8,
  parameter bit SYNC_READ = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PIX_N-1:0]              disc,
  input  logic [TS_W-1:0]               tsNow,
  input  strobe_t                       strobe,
  output logic [SLOTS-1:0][TS_W-1:0]    slotTs,
  output logic [TS_W-1:0]               rdTs,
  output logic [PIX_N*TOT_W-1:0]        rdTot
);
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  logic [PIX_N-1:0][TOT_W-1:0]             totCnt;
  logic [SLOTS-1:0][TS_W-1:0]              tsMem;
  logic [SLOTS-1:0][PIX_N-1:0][TOT_W-1:0]  totMem;

  // Per-pixel time-over-threshold counters
  for (genvar p = 0; p < PIX_N; p++) begin : g_tot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              totCnt[p] <= '0;
      else if (!disc[p])      totCnt[p] <= '0;
      else if (totCnt[p] != TOT_MAX) totCnt[p] <= totCnt[p] + 1'b1;
    end

    AST_TOT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
      (disc[p] && totCnt[p] == TOT_MAX) |=> (totCnt[p] == TOT_MAX)); // R2
  end

  // Event slot storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsMem  <= '0;
      totMem <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (strobe.alloc && strobe.allocSlot == slotIdx_t'(s)) begin
          tsMem[s]  <= tsNow;
          totMem[s] <= '0;
        end
        for (int p = 0; p < PIX_N; p++) begin
          if (strobe.totWr[p] && strobe.totSlot[p] == slotIdx_t'(s))
            totMem[s][p] <= totCnt[p];
        end
      end
    end
  end

  assign slotTs = tsMem;

  if (SYNC_READ) begin : g_syncRead
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdTs  <= '0;
        rdTot <= '0;
      end else if (strobe.rdLoad) begin
        rdTs  <= tsMem[strobe.rdSlot];
        rdTot <= totMem[strobe.rdSlot];
      end
    end
  end else begin : g_asyncRead
    assign rdTs  = tsMem[strobe.rdSlot];
    assign rdTot = totMem[strobe.rdSlot];
  end
endmodule

// File: rtl/pix_region_ctrl.sv
module pix_region_ctrl
  import pix_region_pkg::*;
#(
  parameter int SLOTS     = 7,
  parameter int TS_W      = 8,
  parameter int LAT_W     = 7,
  parameter int CNT_W     = 8,
  parameter bit SYNC_READ = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PIX_N-1:0]            disc,
  input  logic [TS_W-1:0]             tsNow,
  input  logic [LAT_W-1:0]            latency,
  input  logic                        trigger,
  input  logic                        readReady,
  input  logic [SLOTS-1:0][TS_W-1:0]  slotTs,
  output strobe_t                     strobe,
  output logic                        readValid,
  output logic [CNT_W-1:0]            lostCount
);
  localparam int RC_W = $clog2(PIX_N + 1);

  logic [PIX_N-1:0] discQ, rise, fall, ownVal, totWr;
  slotIdx_t [PIX_N-1:0] own;
  logic [SLOTS-1:0] busy, pend, match, expire, freeNow;
  slotIdx_t freeIdx, pendIdx;
  logic anyFree, anyPend, alloc, take, rdLoad;
  logic [TS_W-1:0] latExt;
  logic [RC_W-1:0] riseCnt;
  logic [CNT_W:0] lostSum;

  assign rise    = disc & ~discQ;
  assign fall    = ~disc & discQ;
  assign anyFree = ~&busy;
  assign anyPend = |pend;
  assign alloc   = |rise && anyFree;
  assign latExt  = {{(TS_W-LAT_W){1'b0}}, latency};

  always_comb begin
    freeIdx = '0;
    pendIdx = '0;
    riseCnt = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!busy[s]) freeIdx = slotIdx_t'(s);
      if (pend[s])  pendIdx = slotIdx_t'(s);
    end
    for (int p = 0; p < PIX_N; p++) riseCnt = riseCnt + RC_W'(rise[p]);
  end

  // Latency tracking and trigger matching per slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [TS_W-1:0] age;
    assign age       = tsNow - slotTs[s];
    assign match[s]  = trigger && busy[s] && !pend[s] && age == latExt;
    assign expire[s] = busy[s] && !pend[s] && age > latExt;
    assign freeNow[s] = expire[s] || (take && pendIdx == slotIdx_t'(s));

    AST_EXPIRE_FREES: assert property (@(posedge clk) disable iff (!rstN)
      expire[s] |=> !busy[s]); // R9
  end

  // Readout handshake variant
  if (SYNC_READ) begin : g_syncHs
    logic outValid;
    assign rdLoad    = anyPend && (!outValid || readReady);
    assign take      = rdLoad;
    assign readValid = outValid;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outValid <= 1'b0;
      else       outValid <= rdLoad || (outValid && !readReady);
    end
  end else begin : g_asyncHs
    assign rdLoad    = 1'b0;
    assign take      = anyPend && readReady;
    assign readValid = anyPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discQ <= '0;
      busy  <= '0;
      pend  <= '0;
    end else begin
      discQ <= disc;
      for (int s = 0; s < SLOTS; s++) begin
        busy[s] <= (busy[s] && !freeNow[s]) || (alloc && freeIdx == slotIdx_t'(s));
        pend[s] <= (pend[s] || match[s]) && !freeNow[s];
      end
    end
  end

  // Pixel to slot ownership for ToT write-back
  for (genvar p = 0; p < PIX_N; p++) begin : g_own
    assign totWr[p] = fall[p] && ownVal[p] && busy[own[p]];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ownVal[p] <= 1'b0;
        own[p]    <= '0;
      end else if (rise[p]) begin
        ownVal[p] <= alloc;
        own[p]    <= freeIdx;
      end else if (fall[p] || (ownVal[p] && freeNow[own[p]])) begin
        ownVal[p] <= 1'b0;
      end
    end
  end

  // Hit-loss counter
  assign lostSum = {1'b0, lostCount} + (CNT_W+1)'(riseCnt);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lostCount <= '0;
    else if (|rise && !anyFree) lostCount <= lostSum[CNT_W] ? '1 : lostSum[CNT_W-1:0];
  end

  assign strobe.alloc     = alloc;
  assign strobe.allocSlot = freeIdx;
  assign strobe.totWr     = totWr;
  assign strobe.totSlot   = own;
  assign strobe.rdLoad    = rdLoad;
  assign strobe.rdSlot    = pendIdx;

  AST_LOST_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (|rise && (&busy) && !(&lostCount)) |=> (lostCount != $past(lostCount))); // R10
  AST_ONE_NEW_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busy & ~$past(busy))); // R3
  AST_PEND_IS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (pend & ~busy) == '0); // R5
endmodule

// File: rtl/pix_region_buf.sv
module pix_region_buf
  import pix_region_pkg::*;
#(
  parameter int SLOTS     = 7,
  parameter int TS_W      = 8,
  parameter int LAT_W     = 7,
  parameter int CNT_W     = 8,
  parameter bit SYNC_READ = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PIX_N-1:0]         disc,
  input  logic [TS_W-1:0]          tsNow,
  input  logic [LAT_W-1:0]         latency,
  input  logic                     trigger,
  input  logic                     readReady,
  output logic                     readValid,
  output logic [TS_W-1:0]          readTs,
  output logic [PIX_N*TOT_W-1:0]   readTot,
  output logic [CNT_W-1:0]         lostCount
);
  strobe_t strobe;
  logic [SLOTS-1:0][TS_W-1:0] slotTs;

  pix_region_ctrl #(
    .SLOTS(SLOTS), .TS_W(TS_W), .LAT_W(LAT_W), .CNT_W(CNT_W), .SYNC_READ(SYNC_READ)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .disc(disc), .tsNow(tsNow), .latency(latency),
    .trigger(trigger), .readReady(readReady), .slotTs(slotTs), .strobe(strobe),
    .readValid(readValid), .lostCount(lostCount)
  );

  pix_region_store #(
    .SLOTS(SLOTS), .TS_W(TS_W), .SYNC_READ(SYNC_READ)
  ) i_store (
    .clk(clk), .rstN(rstN), .disc(disc), .tsNow(tsNow), .strobe(strobe),
    .slotTs(slotTs), .rdTs(readTs), .rdTot(readTot)
  );

  if (SYNC_READ) begin : g_holdChk
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (readValid && !readReady) |=> (readValid && $stable(readTs) && $stable(readTot))); // R6
  end
endmodule

// File: tb/test_pix_region_buf.sv
module test_pix_region_buf;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 20;
  // {pixel mask[8:5], pulse length[4:0]}
  localparam logic [8:0] VEC [8] = '{
    {4'b0001, 5'd1}, {4'b0010, 5'd3}, {4'b1111, 5'd5}, {4'b1000, 5'd15},
    {4'b0110, 5'd18}, {4'b1010, 5'd7}, {4'b0100, 5'd2}, {4'b0011, 5'd16}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] disc = '0;
  logic [7:0] tsNow = '0;
  logic [6:0] latency = 7'(LAT);
  logic trigger = 1'b0;
  logic readyS = 1'b0;
  logic readyA = 1'b1;
  logic validS, validA;
  logic [7:0] tsS, tsA, lostS, lostA;
  logic [15:0] totS, totA;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_region_buf i_pix_region_buf (
    .clk(clk), .rstN(rstN), .disc(disc), .tsNow(tsNow), .latency(latency),
    .trigger(trigger), .readReady(readyS), .readValid(validS), .readTs(tsS),
    .readTot(totS), .lostCount(lostS)
  );

  pix_region_buf #(.SYNC_READ(1'b0)) i_pix_region_bufAsync (
    .clk(clk), .rstN(rstN), .disc(disc), .tsNow(tsNow), .latency(latency),
    .trigger(trigger), .readReady(readyA), .readValid(validA), .readTs(tsA),
    .readTot(totA), .lostCount(lostA)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nextCyc();
    @(negedge clk);
    tsNow = tsNow + 8'd1;
  endtask

  task automatic waitUntil(input logic [7:0] t);
    while (tsNow != t) nextCyc();
  endtask

  function automatic logic [15:0] totExp(input logic [3:0] mask, input int len);
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++)
      if (mask[p]) r[4*p +: 4] = (len > 15) ? 4'd15 : 4'(len);
    return r;
  endfunction

  task automatic runVec(input logic [3:0] mask, input int len);
    logic [7:0] c = tsNow;
    disc = mask;
    repeat (len) nextCyc();
    disc = '0;
    waitUntil(c + 8'(LAT));
    trigger = 1'b1;
    nextCyc();
    trigger = 1'b0;
    check("R7 async valid", int'(validA), 1);
    check("R7 async tot", int'(totA), int'(totExp(mask, len)));
    nextCyc();
    check("R6 sync valid", int'(validS), 1);
    check("R4 timestamp", int'(tsS), int'(c));
    check("R2 R3 tot", int'(totS), int'(totExp(mask, len)));
    readyS = 1'b1;
    nextCyc();
    readyS = 1'b0;
    check("R6 released", int'(validS), 0);
  endtask

  initial begin
    logic [7:0] c;
    // R1 reset state
    repeat (3) nextCyc();
    check("R1 valid in reset", int'(validS), 0);
    check("R1 lost in reset", int'(lostS), 0);
    rstN = 1'b1;
    nextCyc();
    check("R1 valid after reset", int'(validS), 0);

    // Table of pulse patterns
    for (int i = 0; i < 8; i++) runVec(VEC[i][8:5], int'(VEC[i][4:0]));

    // R3 staggered rises, R8 two pending events
    c = tsNow;
    disc = 4'b0001; nextCyc();
    disc = 4'b0011; nextCyc();
    disc = 4'b0010; nextCyc();
    nextCyc();
    disc = 4'b0000;
    waitUntil(c + 8'(LAT));
    trigger = 1'b1; nextCyc();
    check("R7 R3 async first ts", int'(tsA), int'(c));
    check("R7 R3 async first tot", int'(totA), 16'h0002);
    nextCyc();
    trigger = 1'b0;
    check("R7 R3 async second ts", int'(tsA), int'(c + 8'd1));
    check("R7 R3 async second tot", int'(totA), 16'h0030);
    check("R8 first valid", int'(validS), 1);
    check("R8 first ts", int'(tsS), int'(c));
    check("R8 first tot", int'(totS), 16'h0002);
    nextCyc();
    check("R6 hold ts", int'(tsS), int'(c));
    check("R6 hold valid", int'(validS), 1);
    readyS = 1'b1;
    nextCyc();
    check("R8 second ts", int'(tsS), int'(c + 8'd1));
    check("R8 second tot", int'(totS), 16'h0030);
    nextCyc();
    readyS = 1'b0;
    check("R8 drained", int'(validS), 0);

    // R5 trigger off by one cycle on either side
    c = tsNow;
    disc = 4'b0100; nextCyc();
    disc = 4'b0000;
    waitUntil(c + 8'(LAT - 1));
    trigger = 1'b1; nextCyc();
    trigger = 1'b0; nextCyc();
    trigger = 1'b1; nextCyc();
    trigger = 1'b0;
    check("R5 async no match", int'(validA), 0);
    nextCyc();
    check("R5 sync no match", int'(validS), 0);

    // R10 overflow, R9 expiry
    c = tsNow;
    for (int k = 0; k < 8; k++) begin
      disc = 4'b0001; nextCyc();
      disc = 4'b0000; nextCyc();
    end
    check("R10 one lost", int'(lostS), 1);
    disc = 4'b1110; nextCyc();
    disc = 4'b0000;
    check("R10 three more lost", int'(lostS), 4);
    check("R10 async count", int'(lostA), 4);
    waitUntil(c + 8'd40);
    c = tsNow;
    disc = 4'b0100;
    repeat (4) nextCyc();
    disc = 4'b0000;
    waitUntil(c + 8'(LAT));
    trigger = 1'b1; nextCyc();
    trigger = 1'b0; nextCyc();
    check("R9 stored after expiry", int'(validS), 1);
    check("R9 ts after expiry", int'(tsS), int'(c));
    check("R9 tot after expiry", int'(totS), 16'h0400);
    check("R9 no new loss", int'(lostS), 4);
    readyS = 1'b1; nextCyc();
    readyS = 1'b0;

    // R1 reset during operation
    c = tsNow;
    disc = 4'b0001; nextCyc(); nextCyc();
    disc = 4'b0000; nextCyc();
    rstN = 1'b0; nextCyc();
    check("R1 lost cleared", int'(lostS), 0);
    check("R1 valid cleared", int'(validS), 0);
    rstN = 1'b1;
    waitUntil(c + 8'(LAT));
    trigger = 1'b1; nextCyc();
    trigger = 1'b0;
    check("R1 old event gone async", int'(validA), 0);
    nextCyc();
    check("R1 old event gone sync", int'(validS), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule